// File: doc/BRIEF.md
# Saturating Q1.15 Multiply / Add / Magnitude Unit

This block is a streaming arithmetic stage for signed two's-complement samples with one sign bit and fifteen fractional bits. Each accepted transfer carries two operands and a two-bit operation code. The unit then does one of four things:

- multiplies the operands and rescales the product back to Q1.15;
- adds them and delivers the sum with one extra integer bit (Q2.14);
- returns the magnitude of the first operand;
- returns zero for the reserved code.

Every rescaled result is rounded to nearest. Every result that leaves the representable range is clamped to the nearest bound, and a per-result flag reports that the clamp was used.

Both sides use a valid/ready handshake. The two-stage pipeline stalls as a whole when the consumer deasserts ready, so no sample is lost or reordered. The first stage registers the raw 32-bit product, the widened sum and the first operand. The second stage rounds, clamps and registers the result together with its flag.

Top module: `fxq_alu`

## Requirements
- R1: After reset `oValid` is low and `iReady` is high.
- R2: Operation code 2'b00 (multiply) returns floor((A*B + 0x4000) / 2^15) using the full 32-bit product. Ties therefore round toward positive infinity, and the error against the exact product is at most half an output LSB.
- R3: Multiplying 0x8000 by 0x8000 (-1.0 times -1.0) returns 0x7FFF with `oSat` high. This is the only multiply that clamps.
- R4: Operation code 2'b01 (add) returns floor((A + B + 1) / 2) as a Q2.14 code. This path never overflows and never raises `oSat`.
- R5: Operation code 2'b10 (magnitude) returns |A| and ignores B entirely.
- R6: The magnitude of 0x8000 returns 0x7FFF with `oSat` high instead of wrapping.
- R7: Operation code 2'b11 is reserved. It returns 0x0000 with `oSat` low.
- R8: `oSat` is high exactly when the result was clamped, and a flagged result is always 0x7FFF or 0x8000.
- R9: With `oReady` held high, a transfer accepted at one rising edge shows its result on `oValid`/`oData` after the second rising edge that follows.
- R10: While `oValid` is high and `oReady` is low:
  - `oValid`, `oData` and `oSat` hold their values;
  - `iReady` is low;
  - every accepted sample later leaves the unit once, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| iValid | input | 1 | Input transfer offered |
| iReady | output | 1 | Unit can take an input transfer |
| iOpSel | input | 2 | Operation code (00 mul, 01 add, 10 magnitude, 11 reserved) |
| iOpA | input | 16 | Operand A, Q1.15 |
| iOpB | input | 16 | Operand B, Q1.15 |
| oValid | output | 1 | Result available |
| oReady | input | 1 | Consumer takes the result |
| oData | output | 16 | Result: Q1.15, or Q2.14 for add |
| oSat | output | 1 | Result was clamped to a bound |

## Verification
A result is due two rising edges after its input handshake, provided the output side is not stalled. Any stall cycles with `oReady` low push the result out by the same number of cycles.

The bench drives inputs and samples outputs on the falling edge. It decides acceptance from `iValid` and `iReady`, and completion from `oValid` and `oReady`, using values that are stable before the next rising edge. Expected results go into an in-order queue at acceptance and come out of it at completion, so any loss, duplication or reordering shows up as a mismatch.

A directed sequence counts falling edges from acceptance to confirm the exact two-cycle latency. It then holds `oReady` low for several cycles to confirm that the output is frozen and that `iReady` drops.

// File: rtl/fxq_pkg.sv
package fxq_pkg;

  typedef enum logic [1:0] {
    OP_MUL = 2'b00,
    OP_ADD = 2'b01,
    OP_ABS = 2'b10,
    OP_RSV = 2'b11
  } fxq_op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;   // whole pipeline moves one step
    logic outFull;   // result register holds a live sample
  } fxq_strobe_t;

endpackage

// File: rtl/fxq_ctrl.sv
module fxq_ctrl
  import fxq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        iValid,
  output logic        iReady,
  output logic        oValid,
  input  logic        oReady,
  output fxq_strobe_t stb
);

  logic midFull;
  logic lastFull;
  logic advance;

  // whole-pipe stall: only a live, unconsumed result blocks motion
  assign advance = !(lastFull && !oReady);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      midFull  <= 1'b0;
      lastFull <= 1'b0;
    end else if (advance) begin
      midFull  <= iValid;
      lastFull <= midFull;
    end
  end

  assign iReady      = advance;
  assign oValid      = lastFull;
  assign stb.advance = advance;
  assign stb.outFull = lastFull;

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (oValid && !oReady) |=> oValid); // R10

  AST_NO_ACCEPT_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (oValid && !oReady) |-> !iReady); // R10

  AST_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (iValid && iReady) ##1 advance |=> oValid); // R9

  AST_ENTRY_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (iValid && iReady) |=> midFull); // R10

endmodule

// File: rtl/fxq_datapath.sv
module fxq_datapath
  import fxq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  fxq_strobe_t       stb,
  input  logic [1:0]        opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] resData,
  output logic              resSat
);

  localparam int PROD_W = 2 * DATA_W;
  localparam int ACC_W  = PROD_W + 1;
  localparam int SUM_W  = DATA_W + 1;
  localparam int MAX_I  = (1 <<< (DATA_W - 1)) - 1;
  localparam int MIN_I  = -(1 <<< (DATA_W - 1));
  localparam logic signed [ACC_W-1:0]  MAX_W    = ACC_W'(MAX_I);
  localparam logic signed [ACC_W-1:0]  MIN_W    = ACC_W'(MIN_I);
  localparam logic signed [ACC_W-1:0]  HALF_W   = ACC_W'(1) <<< (FRAC_W - 1);
  localparam logic        [DATA_W-1:0] MAX_CODE = DATA_W'(MAX_I);
  localparam logic        [DATA_W-1:0] MIN_CODE = DATA_W'(MIN_I);

  // stage 1: raw product, widened sum, operand A, op code
  logic signed [PROD_W-1:0] prodQ;
  logic signed [SUM_W-1:0]  sumQ;
  logic signed [DATA_W-1:0] aQ;
  fxq_op_e                  opQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodQ <= '0;
      sumQ  <= '0;
      aQ    <= '0;
      opQ   <= OP_RSV;
    end else if (stb.advance) begin
      prodQ <= $signed(opA) * $signed(opB);
      sumQ  <= $signed({opA[DATA_W-1], opA}) + $signed({opB[DATA_W-1], opB});
      aQ    <= $signed(opA);
      opQ   <= fxq_op_e'(opSel);
    end
  end

  // multiply: round half up, shift, clamp
  logic signed [ACC_W-1:0] prodRnd;
  logic signed [ACC_W-1:0] prodScaled;
  logic [DATA_W-1:0]       mulRes;
  logic                    mulSat;

  always_comb begin
    prodRnd    = $signed({prodQ[PROD_W-1], prodQ}) + HALF_W;
    prodScaled = prodRnd >>> FRAC_W;
    if (prodScaled > MAX_W) begin
      mulRes = MAX_CODE;
      mulSat = 1'b1;
    end else if (prodScaled < MIN_W) begin
      mulRes = MIN_CODE;
      mulSat = 1'b1;
    end else begin
      mulRes = prodScaled[DATA_W-1:0];
      mulSat = 1'b0;
    end
  end

  // add: one-bit rescale to Q2.14 with round half up
  logic signed [SUM_W:0] sumRnd;
  logic [DATA_W-1:0]     addRes;

  always_comb begin
    sumRnd = $signed({sumQ[SUM_W-1], sumQ}) + $signed((SUM_W+1)'(1));
    addRes = sumRnd[DATA_W:1];
  end

  // magnitude with clamp of the most negative code
  logic [DATA_W-1:0] absRes;
  logic              absSat;

  always_comb begin
    absSat = (aQ == $signed(MIN_CODE));
    if (absSat)               absRes = MAX_CODE;
    else if (aQ[DATA_W-1])    absRes = DATA_W'(-aQ);
    else                      absRes = aQ;
  end

  // stage 2: select and register
  logic [DATA_W-1:0] nxtRes;
  logic              nxtSat;

  always_comb begin
    unique case (opQ)
      OP_MUL: begin nxtRes = mulRes; nxtSat = mulSat; end
      OP_ADD: begin nxtRes = addRes; nxtSat = 1'b0;   end
      OP_ABS: begin nxtRes = absRes; nxtSat = absSat; end
      default: begin nxtRes = '0;    nxtSat = 1'b0;   end
    endcase
  end

  logic [DATA_W-1:0] resQ;
  logic              satQ;
  fxq_op_e           op2Q;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resQ <= '0;
      satQ <= 1'b0;
      op2Q <= OP_RSV;
    end else if (stb.advance) begin
      resQ <= nxtRes;
      satQ <= nxtSat;
      op2Q <= opQ;
    end
  end

  assign resData = resQ;
  assign resSat  = satQ;

  AST_SAT_AT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (stb.outFull && resSat) |-> (resData == MAX_CODE || resData == MIN_CODE)); // R8

  AST_ADD_NO_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (stb.outFull && op2Q == OP_ADD) |-> !resSat); // R4

  AST_ABS_NONNEG: assert property (@(posedge clk) disable iff (!rstN)
    (stb.outFull && op2Q == OP_ABS) |-> !resData[DATA_W-1]); // R5

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.outFull && op2Q == OP_RSV) |-> (resData == '0 && !resSat)); // R7

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (stb.outFull && !stb.advance) |=> ($stable(resData) && $stable(resSat))); // R10

endmodule

// File: rtl/fxq_alu.sv
module fxq_alu
  import fxq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              iValid,
  output logic              iReady,
  input  logic [1:0]        iOpSel,
  input  logic [DATA_W-1:0] iOpA,
  input  logic [DATA_W-1:0] iOpB,
  output logic              oValid,
  input  logic              oReady,
  output logic [DATA_W-1:0] oData,
  output logic              oSat
);

  fxq_strobe_t stb;

  fxq_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .iValid (iValid),
    .iReady (iReady),
    .oValid (oValid),
    .oReady (oReady),
    .stb    (stb)
  );

  fxq_datapath #(
    .DATA_W (DATA_W),
    .FRAC_W (FRAC_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .opSel   (iOpSel),
    .opA     (iOpA),
    .opB     (iOpB),
    .resData (oData),
    .resSat  (oSat)
  );

endmodule

// File: tb/fxq_alu_tb_top.sv
`timescale 1ns/1ps
module fxq_alu_tb_top;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        iValid = 1'b0;
  logic        iReady;
  logic [1:0]  iOpSel = 2'b00;
  logic [15:0] iOpA = '0;
  logic [15:0] iOpB = '0;
  logic        oValid;
  logic        oReady = 1'b0;
  logic [15:0] oData;
  logic        oSat;

  int nChecks = 0;
  int nErr    = 0;

  fxq_alu dut_i (
    .clk(clk), .rstN(rstN), .iValid(iValid), .iReady(iReady),
    .iOpSel(iOpSel), .iOpA(iOpA), .iOpB(iOpB),
    .oValid(oValid), .oReady(oReady), .oData(oData), .oSat(oSat)
  );

  localparam int N_CORNER = 14;
  localparam int N_MUL    = 12000;
  localparam int N_ADD    = 8000;
  localparam int N_ABS    = 65536;
  localparam int N_RSV    = 64;
  localparam int N_TOTAL  = N_CORNER + N_MUL + N_ADD + N_ABS + N_RSV;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model from the requirements
  function automatic void model(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b,
                                output logic [15:0] d, output logic s, output longint p);
    longint r;
    s = 1'b0;
    p = longint'($signed(a)) * longint'($signed(b));
    case (op)
      2'b00: begin
        r = (p + 64'sd16384) >>> 15;
        if (r > 32767) begin r = 32767; s = 1'b1; end
        else if (r < -32768) begin r = -32768; s = 1'b1; end
        d = r[15:0];
      end
      2'b01: begin
        r = (longint'($signed(a)) + longint'($signed(b)) + 1) >>> 1;
        d = r[15:0];
      end
      2'b10: begin
        if (a == 16'h8000) begin d = 16'h7FFF; s = 1'b1; end
        else if (a[15]) d = 16'(-$signed(a));
        else d = a;
      end
      default: d = 16'h0000;
    endcase
  endfunction

  function automatic string tagOf(input logic [1:0] op, input logic s);
    case (op)
      2'b00:   return s ? "R3" : "R2";
      2'b01:   return "R4";
      2'b10:   return s ? "R6" : "R5";
      default: return "R7";
    endcase
  endfunction

  // transaction generator by index
  task automatic getTx(input int idx, output logic [1:0] op, output logic [15:0] a, output logic [15:0] b);
    a = 16'($urandom);
    b = 16'($urandom);
    if (idx < N_CORNER) begin
      case (idx)
        0:  begin op = 2'b00; a = 16'h8000; b = 16'h8000; end // R3 overflow
        1:  begin op = 2'b00; a = 16'h8000; b = 16'h7FFF; end
        2:  begin op = 2'b00; a = 16'h7FFF; b = 16'h7FFF; end
        3:  begin op = 2'b00; a = 16'h0001; b = 16'h4000; end // tie up -> 1
        4:  begin op = 2'b00; a = 16'hFFFF; b = 16'h4000; end // tie -> 0
        5:  begin op = 2'b00; a = 16'h0000; b = 16'h8000; end
        6:  begin op = 2'b01; a = 16'h7FFF; b = 16'h7FFF; end
        7:  begin op = 2'b01; a = 16'h8000; b = 16'h8000; end
        8:  begin op = 2'b01; a = 16'h0001; b = 16'h0000; end
        9:  begin op = 2'b01; a = 16'hFFFF; b = 16'h0000; end
        10: begin op = 2'b10; a = 16'h8000; end
        11: begin op = 2'b10; a = 16'h8001; end
        12: begin op = 2'b10; a = 16'h7FFF; end
        default: begin op = 2'b11; a = 16'h8000; b = 16'h8000; end
      endcase
    end else if (idx < N_CORNER + N_MUL) op = 2'b00;
    else if (idx < N_CORNER + N_MUL + N_ADD) op = 2'b01;
    else if (idx < N_CORNER + N_MUL + N_ADD + N_ABS) begin
      op = 2'b10;
      a  = 16'(idx - (N_CORNER + N_MUL + N_ADD)); // every code, B random (ignored)
    end else op = 2'b11;
  endtask

  logic [15:0] qD[$];
  logic        qS[$];
  logic [1:0]  qOp[$];
  longint      qP[$];

  initial begin : main
    logic [15:0] d, a, b;
    logic        s;
    logic [1:0]  op;
    longint      p;
    int          txIdx, outCnt;
    logic        loaded;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check("R1 oValid after reset", 32'(oValid), 32'd0);
    check("R1 iReady after reset", 32'(iReady), 32'd1);

    // latency: 0.5 * 0.5
    iValid = 1'b1; iOpSel = 2'b00; iOpA = 16'h4000; iOpB = 16'h4000; oReady = 1'b1;
    #1;
    check("R9 accept", 32'(iReady), 32'd1);
    @(negedge clk);
    iValid = 1'b0;
    #1;
    check("R9 not yet valid", 32'(oValid), 32'd0);
    @(negedge clk);
    oReady = 1'b0;
    iValid = 1'b1; iOpSel = 2'b01; iOpA = 16'h4000; iOpB = 16'h4000;
    #1;
    check("R9 valid after two edges", 32'(oValid), 32'd1);
    check("R2 0.5*0.5", 32'(oData), 32'h2000);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1;
      check("R10 valid held", 32'(oValid), 32'd1);
      check("R10 data held", 32'(oData), 32'h2000);
      check("R10 iReady low", 32'(iReady), 32'd0);
    end
    oReady = 1'b1;
    #1;
    check("R10 release", 32'(iReady), 32'd1);
    @(negedge clk);
    iValid = 1'b0;
    #1;
    check("R10 bubble after stall", 32'(oValid), 32'd0);
    @(negedge clk);
    #1;
    check("R10 queued add valid", 32'(oValid), 32'd1);
    check("R4 0.5+0.5 in Q2.14", 32'(oData), 32'h4000);
    check("R4 add sat low", 32'(oSat), 32'd0);
    @(negedge clk);

    // sweep with random backpressure
    txIdx = 0; outCnt = 0; loaded = 1'b0;
    while (outCnt < N_TOTAL) begin
      if (!loaded && txIdx < N_TOTAL) begin
        getTx(txIdx, op, a, b);
        iOpSel = op; iOpA = a; iOpB = b; iValid = 1'b1; loaded = 1'b1;
      end
      oReady = ($urandom % 4) != 0;
      #1;
      if (oValid && oReady) begin
        if (qD.size() == 0) begin
          check("R10 unexpected output", 32'd1, 32'd0);
        end else begin
          d = qD.pop_front(); s = qS.pop_front(); op = qOp.pop_front(); p = qP.pop_front();
          check(tagOf(op, s), 32'(oData), 32'(d));
          check("R8 sat flag", 32'(oSat), 32'(s));
          if (op == 2'b00 && !oSat) begin
            longint err;
            err = longint'($signed(oData)) * 32768 - p;
            check("R2 error within half LSB", 32'(err <= 16384 && err >= -16384), 32'd1);
          end
        end
        outCnt++;
      end
      if (iValid && iReady) begin
        model(iOpSel, iOpA, iOpB, d, s, p);
        qD.push_back(d); qS.push_back(s); qOp.push_back(iOpSel); qP.push_back(p);
        txIdx++;
        loaded = 1'b0;
      end
      @(negedge clk);
      if (!loaded) iValid = 1'b0;
    end
    check("R10 queue drained", 32'(qD.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    nErr++;
    nChecks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule